// File: doc/BRIEF.md
# Burst Column Order Generator

This block produces the column addresses of one memory burst, one beat at a time. A start pulse captures a starting column, a burst length code and an ordering choice. From the next cycle on, the block shows the column of the current beat together with a valid flag. Each cycle in which the consumer raises the advance input moves the block to the next beat. A memory model or a controller that tracks data beats uses it to learn which column every beat belongs to.

Two orderings are supported. Sequential ordering counts the low address bits upward and wraps inside the aligned block that the burst length defines. Interleaved ordering XORs the beat number into those low bits. A full-row burst walks all 256 columns of the row, wraps from the top back to column 0, and keeps going until the terminate input is raised. A start request that asks for interleaved ordering with a full-row length, or that uses an unassigned length code, is rejected: it is flagged and it produces no beats.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o, last_o and illegal_o are low.
- R2: A legal start_i makes valid_o high on the next cycle, with col_o equal to the captured start column (beat 0).
- R3: The length codes are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for a full row. When ilv_i is 0 at start, beat k shows the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits stay unchanged.
- R4: When ilv_i is 1 at start, beat k shows the start column with its low log2(BL) bits XORed with k.
- R5: Each rising edge with valid_o and advance_i high moves to the next beat. While advance_i is low, col_o holds.
- R6: last_o is high exactly on the final beat of a fixed-length burst. If that beat is advanced with no new start, valid_o falls on the next cycle.
- R7: A legal start_i in the cycle where the final beat is advanced shows the new start column on the next cycle, and valid_o stays high with no gap.
- R8: A full-row burst (code 7, sequential) runs col_o from the start column upward, wrapping from 255 to 0. It keeps going until terminated, and last_o stays low throughout.
- R9: term_i during a valid beat makes that beat the final one, so valid_o is low on the next cycle. A legal start_i in the same cycle takes precedence.
- R10: A start_i with ilv_i = 1 and code 7, or with code 4, 5 or 6, raises illegal_o for one cycle on the next cycle. It produces no beats and leaves a running burst untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| advance_i | input | 1 | Consume the current beat |
| term_i | input | 1 | End the burst after the current beat |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |
| illegal_o | output | 1 | The previous cycle's start request was rejected |

## Verification
Two functions can land in the same cycle: the retirement of the final beat, which is either the last advanced beat or a terminated one, and the acceptance of a new start. The bench raises start_i in exactly the cycle where last_o and advance_i are both high. It then checks that the very next sample still has valid_o high and shows the new burst's first column in the new ordering. It also issues a rejected start in the middle of a running burst and checks that the beat sequence continues undisturbed while illegal_o pulses.

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             advance_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             illegal_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q, ilv_q, full_q, illegal_q;
  logic [COL_W-1:0] beat_q, base_q, mask_q;
  logic [COL_W-1:0] mask_d, lanes;
  logic             legal, accept, at_last;

  always_comb begin
    mask_d = '0;
    legal  = 1'b0;
    case (len_code_i)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        mask_d = (ONE << len_code_i) - ONE;
        legal  = 1'b1;
      end
      3'd7: begin
        mask_d = '1;
        legal  = !ilv_i;
      end
      default: ;
    endcase
  end

  assign accept  = start_i && legal;
  assign at_last = active_q && !full_q && (beat_q == mask_q);
  assign lanes   = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      beat_q    <= '0;
      base_q    <= '0;
      mask_q    <= '0;
      ilv_q     <= 1'b0;
      full_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= start_i && !legal;
      if (accept) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        base_q   <= start_col_i;
        mask_q   <= mask_d;
        ilv_q    <= ilv_i;
        full_q   <= (len_code_i == 3'd7);
      end else if (active_q && (term_i || (advance_i && at_last))) begin
        active_q <= 1'b0;
      end else if (active_q && advance_i) begin
        beat_q <= beat_q + ONE;
      end
    end
  end

  assign col_o     = (base_q & ~mask_q) | (lanes & mask_q);
  assign valid_o   = active_q;
  assign last_o    = at_last;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
`timescale 1ns/1ps
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             ilv_i,
  input logic             advance_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             illegal_o
);
  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_code_i < 3'd4) |=> (valid_o && col_o == $past(start_col_i)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !advance_i && !start_i && !term_i) |=> (valid_o && $stable(col_o)));

  a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && advance_i && !start_i && !term_i) |=> !valid_o);

  a_r9_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i && !start_i) |=> !valid_o);

  a_r10_reject_full_ilv: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ilv_i && len_code_i == 3'd7) |=> illegal_o);

  a_r10_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(start_i));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       advance_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, illegal_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .advance_i(advance_i),
    .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
    .illegal_o(illegal_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int base, input int code, input bit ilv, input int k);
    int m = (code == 7) ? 255 : ((1 << code) - 1);
    int low = ilv ? (base ^ k) : (base + k);
    return (base & ~m & 255) | (low & m);
  endfunction

  task automatic issue(input int col, input int code, input bit ilv);
    start_i = 1'b1; start_col_i = 8'(col); len_code_i = 3'(code); ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", int'(valid_o), 0);
    check("R1 last", int'(last_o), 0);
    check("R1 illegal", int'(illegal_o), 0);
  endtask

  task automatic t_fixed(input int col, input int code, input bit ilv);
    int n = 1 << code;
    advance_i = 1'b1;
    issue(col, code, ilv);
    check("R2 first beat", int'(col_o), col);
    for (int k = 0; k < n; k++) begin
      check(ilv ? "R4 column" : "R3 column", int'(col_o), exp_col(col, code, ilv, k));
      check("R5 valid", int'(valid_o), 1);
      check("R6 last", int'(last_o), int'(k == n - 1));
      @(negedge clk);
    end
    check("R6 valid drops", int'(valid_o), 0);
  endtask

  task automatic t_full_page();
    advance_i = 1'b1;
    issue(8'hFE, 7, 1'b0);
    for (int k = 0; k < 300; k++) begin
      check("R8 column", int'(col_o), (8'hFE + k) & 255);
      check("R8 no last", int'(last_o), 0);
      if (k == 299) term_i = 1'b1;
      @(negedge clk);
    end
    term_i = 1'b0;
    check("R9 term ends full page", int'(valid_o), 0);
  endtask

  task automatic t_back_to_back();
    advance_i = 1'b1;
    issue(8'h12, 2, 1'b0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R7 last before restart", int'(last_o), 1);
    issue(8'h81, 2, 1'b1);
    check("R7 no gap valid", int'(valid_o), 1);
    for (int k = 0; k < 4; k++) begin
      check("R7 new burst column", int'(col_o), 8'h81 ^ k);
      @(negedge clk);
    end
    check("R7 ends", int'(valid_o), 0);
  endtask

  task automatic t_hold();
    advance_i = 1'b0;
    issue(8'h40, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check("R5 hold column", int'(col_o), 8'h40);
      check("R5 hold valid", int'(valid_o), 1);
      @(negedge clk);
    end
    advance_i = 1'b1;
    @(negedge clk);
    check("R5 resume", int'(col_o), 8'h41);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
  endtask

  task automatic t_illegal();
    advance_i = 1'b1;
    issue(8'h33, 7, 1'b1);
    check("R10 flag full+ilv", int'(illegal_o), 1);
    check("R10 no beat", int'(valid_o), 0);
    @(negedge clk);
    check("R10 flag one cycle", int'(illegal_o), 0);
    issue(8'h10, 3, 1'b0);
    @(negedge clk);
    @(negedge clk);
    issue(8'h77, 5, 1'b0);
    check("R10 flag reserved", int'(illegal_o), 1);
    check("R10 burst untouched", int'(col_o), 8'h13);
    check("R10 still valid", int'(valid_o), 1);
  endtask

  task automatic t_term_mid();
    advance_i = 1'b1;
    issue(8'h20, 3, 1'b1);
    @(negedge clk);
    check("R9 beat before term", int'(col_o), 8'h21);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check("R9 valid low", int'(valid_o), 0);
    advance_i = 1'b1;
    issue(8'h50, 1, 1'b0);
    term_i = 1'b1;
    issue(8'h66, 0, 1'b0);
    term_i = 1'b0;
    check("R9 start wins", int'(col_o), 8'h66);
    check("R9 start wins valid", int'(valid_o), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed(8'h35, 3, 1'b0);
    t_fixed(8'h35, 3, 1'b1);
    t_fixed(8'hA7, 2, 1'b0);
    t_fixed(8'hA6, 2, 1'b1);
    t_fixed(8'h0B, 1, 1'b0);
    t_fixed(8'h0B, 1, 1'b1);
    t_fixed(8'hC9, 0, 1'b0);
    t_full_page();
    t_back_to_back();
    t_hold();
    t_illegal();
    t_term_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule